// File: doc/BRIEF.md
# Sleep-Aware Interrupt Offload Controller

This block sits between a set of external interrupt lines and a host processor that has power-saving states. Every line is synchronized, can be masked, and is conditioned by a trigger mode that can be set per line. The block then routes each event down one of two paths.

On the pass-through path, the event goes straight to the host interrupt. On the local path, the event is queued and later handed to a local handler through a start/done handshake. Queued local requests are dispatched one at a time by a small state machine. Its states are `DSP_IDLE`, `DSP_LAUNCH` and `DSP_WAIT`, with these transitions:
- `DSP_IDLE` to `DSP_LAUNCH`: taken when an eligible request exists. The winner is latched and its request bit is cleared.
- `DSP_LAUNCH` to `DSP_WAIT`: taken unconditionally after the one-cycle start pulse.
- `DSP_WAIT` to `DSP_IDLE`: taken when the handler reports done. The result is recorded at that edge.

Every reported event sets a bit in a pending register. The host power-state pins are synchronized and watched. When the host is running, any unmasked pending bit drives the host interrupt. When the host is idle or asleep, a locally completed event drives the interrupt only if its source is wake-enabled and its priority is at or above a threshold. A completed event that does not qualify stays silently pending until the host runs again. The host clears pending bits by writing ones to them. A register reports the most recently reported source.

Top module: `irq_offload_ctrl`

## Requirements
- R1: A source whose mask bit is 1 (register 0, bit i) is ignored completely. It sets no pending bit, raises no host interrupt and starts no handler. All mask bits reset to 1.
- R2: Each source's trigger mode is field bits [1:0] of its config register (address 8+i), with these encodings:
  - 0: active-high level
  - 1: active-low level
  - 2: rising edge
  - 3: falling edge
- R3: An input change is seen by the routing logic after a two-flop synchronizer. A pass-through event sets its pending bit and the host interrupt on the third rising clock edge after the change, and not earlier. A single-cycle input pulse is not lost.
- R4: A source whose local bit (register 1, bit i) is 0 is forwarded: its event raises the host interrupt whatever the host power state.
- R5: The handshake for a local source (local bit 1) runs in this order:
  - Its event makes `hnd_start` pulse for exactly one cycle, with `hnd_id` holding the source index steady until `hnd_done`.
  - The host interrupt stays low until the handler finishes.
  - The pending bit is set at the clock edge that samples `hnd_done` high.
- R6: Host power encoding on `host_pwr` is 00 run, 01 idle, 10 and 11 sleep. While the host is not running, a completed local event sets its pending bit. It raises the host interrupt only if its wake-enable bit (register 2, bit i) is 1 and its priority (config bits [3:2]) is at least `HI_PRI`.
- R7: When `host_pwr` returns to run, the host interrupt is raised for any unmasked pending bit within two clock edges.
- R8: Writing 1 to bit i of the pending register (address 3) clears that bit. A write in the same cycle as a new event for that source leaves the bit set, so an active level source stays pending.
- R9: When several local requests wait, they are dispatched highest priority first. Among equal priorities the lowest index goes first.
- R10: The last-source register (address 4) reads bit 7 = 1 and the low bits = index of the most recently reported source. If several sources are reported at once, the lowest index is recorded.
- R11: After reset the following all read 0: local, wake-enable, pending and last-source registers, `host_irq` and `hnd_start`. The mask register reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | External interrupt lines |
| host_pwr | input | 2 | Host power-state pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| hnd_start | output | 1 | One-cycle start pulse to the local handler |
| hnd_id | output | IDW | Index of the source being handled |
| hnd_done | input | 1 | Handler completion strobe |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
Each result has a fixed latency after its stimulus:
- A pass-through event reaches `host_irq` and the pending register on the third rising edge after the input changes.
- A local event raises `hnd_start` after the fourth edge. The matching pending bit follows on the edge that samples `hnd_done`.
- A change on `host_pwr` takes effect two edges later.
- Register writes land on the next edge, and reads are combinational.

The bench drives all inputs on falling edges and samples on falling edges at exactly these counts. For latency it checks both the cycle before the result is due (still low) and the cycle it is due. Its handler model answers a fixed three cycles after each start, so dispatch order and completion timing are known in advance.

// File: rtl/irq_ofl_pkg.sv
`timescale 1ns/1ps
package irq_ofl_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        DSP_IDLE   = 2'd0,
        DSP_LAUNCH = 2'd1,
        DSP_WAIT   = 2'd2
    } dsp_state_e;

    localparam logic [1:0] PWR_RUN = 2'b00;

    localparam int RA_MASK  = 0;
    localparam int RA_LOCAL = 1;
    localparam int RA_WAKE  = 2;
    localparam int RA_PEND  = 3;
    localparam int RA_LAST  = 4;
    localparam int RA_CFG0  = 8;

endpackage

// File: rtl/irq_src_cond.sv
`timescale 1ns/1ps
module irq_src_cond
    import irq_ofl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_i,
    input  trig_e mode_i,
    output logic  event_o
);

    // two synchronizer flops plus one history flop for edge detection
    logic [2:0] shf_q;
    logic       lvl;
    logic       prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= {shf_q[1:0], pin_i};
    end

    assign lvl  = shf_q[1];
    assign prev = shf_q[2];

    always_comb begin
        unique case (mode_i)
            TRIG_LVL_HI: event_o = lvl;
            TRIG_LVL_LO: event_o = ~lvl;
            TRIG_RISE:   event_o = lvl & ~prev;
            TRIG_FALL:   event_o = ~lvl & prev;
            default:     event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
    import irq_ofl_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int PRI_W = 2,
    parameter int AW    = 4,
    parameter int DW    = 8,
    localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [DW-1:0]               wdata_i,
    input  logic [NSRC-1:0]             pend_i,
    input  logic                        last_vld_i,
    input  logic [IDW-1:0]              last_id_i,
    output logic [DW-1:0]               rdata_o,
    output logic [NSRC-1:0]             mask_o,
    output logic [NSRC-1:0]             local_o,
    output logic [NSRC-1:0]             wake_o,
    output logic [NSRC-1:0][1:0]        mode_o,
    output logic [NSRC-1:0][PRI_W-1:0]  prio_o,
    output logic [NSRC-1:0]             clr_o
);

    logic unused_wbits;
    assign unused_wbits = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o  <= '1;
            local_o <= '0;
            wake_o  <= '0;
            mode_o  <= '0;
            prio_o  <= '0;
        end else if (we_i) begin
            if (int'(addr_i) == RA_MASK)  mask_o  <= wdata_i[NSRC-1:0];
            if (int'(addr_i) == RA_LOCAL) local_o <= wdata_i[NSRC-1:0];
            if (int'(addr_i) == RA_WAKE)  wake_o  <= wdata_i[NSRC-1:0];
            for (int i = 0; i < NSRC; i++) begin
                if (int'(addr_i) == RA_CFG0 + i) begin
                    mode_o[i] <= wdata_i[1:0];
                    prio_o[i] <= wdata_i[2 +: PRI_W];
                end
            end
        end
    end

    assign clr_o = (we_i && int'(addr_i) == RA_PEND) ? wdata_i[NSRC-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        if (int'(addr_i) == RA_MASK)  rdata_o[NSRC-1:0] = mask_o;
        if (int'(addr_i) == RA_LOCAL) rdata_o[NSRC-1:0] = local_o;
        if (int'(addr_i) == RA_WAKE)  rdata_o[NSRC-1:0] = wake_o;
        if (int'(addr_i) == RA_PEND)  rdata_o[NSRC-1:0] = pend_i;
        if (int'(addr_i) == RA_LAST) begin
            rdata_o[DW-1]    = last_vld_i;
            rdata_o[IDW-1:0] = last_id_i;
        end
        for (int i = 0; i < NSRC; i++) begin
            if (int'(addr_i) == RA_CFG0 + i) begin
                rdata_o[1:0]       = mode_o[i];
                rdata_o[2 +: PRI_W] = prio_o[i];
            end
        end
    end

endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
    parameter int NSRC  = 4,
    parameter int PRI_W = 2,
    localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]            req_i,
    input  logic [NSRC-1:0][PRI_W-1:0] prio_i,
    output logic                       any_o,
    output logic [IDW-1:0]             win_o
);

    logic [PRI_W-1:0] best_p;

    // strict greater-than keeps the lowest index on a tie
    always_comb begin
        any_o  = 1'b0;
        win_o  = '0;
        best_p = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (!any_o || prio_i[i] > best_p)) begin
                any_o  = 1'b1;
                win_o  = IDW'(i);
                best_p = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_dispatch_fsm.sv
`timescale 1ns/1ps
module irq_dispatch_fsm
    import irq_ofl_pkg::*;
#(
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_i,
    input  logic [IDW-1:0] win_i,
    input  logic           done_i,
    output logic           start_o,
    output logic [IDW-1:0] id_o,
    output logic           grant_o,
    output logic           report_o,
    output logic           wait_o
);

    dsp_state_e state_q, state_d;
    logic [IDW-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cur_q <= '0;
        else if (grant_o) cur_q <= win_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DSP_IDLE:   if (any_i)  state_d = DSP_LAUNCH;
            DSP_LAUNCH:             state_d = DSP_WAIT;
            DSP_WAIT:   if (done_i) state_d = DSP_IDLE;
            default:                state_d = DSP_IDLE;
        endcase
    end

    always_comb begin
        grant_o  = 1'b0;
        start_o  = 1'b0;
        report_o = 1'b0;
        wait_o   = 1'b0;
        unique case (state_q)
            DSP_IDLE:   grant_o = any_i;
            DSP_LAUNCH: start_o = 1'b1;
            DSP_WAIT: begin
                wait_o   = 1'b1;
                report_o = done_i;
            end
            default: ;
        endcase
    end

    assign id_o = cur_q;

endmodule

// File: rtl/irq_offload_ctrl.sv
`timescale 1ns/1ps
module irq_offload_ctrl
    import irq_ofl_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int PRI_W  = 2,
    parameter int HI_PRI = 2,
    parameter int AW     = 4,
    parameter int DW     = 8,
    localparam int IDW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [1:0]      host_pwr,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            hnd_start,
    output logic [IDW-1:0]  hnd_id,
    input  logic            hnd_done,
    output logic            host_irq
);

    logic [NSRC-1:0]            mask_q, local_q, wake_en_q, clr;
    logic [NSRC-1:0][1:0]       mode_q;
    logic [NSRC-1:0][PRI_W-1:0] prio_q;
    logic [NSRC-1:0]            ev, ev_live, req_q, pass_set, rep_set;
    logic [NSRC-1:0]            pend_set, pend_q, wake_q, urgent, grant_vec;
    logic [1:0]                 pwr_s1, pwr_s2;
    logic                       run_s, any_req, grant, report, in_wait;
    logic [IDW-1:0]             win_id, last_id, last_nxt;
    logic                       last_vld;

    irq_cfg_regs #(.NSRC(NSRC), .PRI_W(PRI_W), .AW(AW), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .pend_i(pend_q), .last_vld_i(last_vld),
        .last_id_i(last_id), .rdata_o(reg_rdata), .mask_o(mask_q),
        .local_o(local_q), .wake_o(wake_en_q), .mode_o(mode_q),
        .prio_o(prio_q), .clr_o(clr)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        irq_src_cond cond_i (
            .clk(clk), .rst_n(rst_n), .pin_i(src_i[g]),
            .mode_i(trig_e'(mode_q[g])), .event_o(ev[g])
        );
        assign urgent[g] = wake_en_q[g] && (prio_q[g] >= PRI_W'(HI_PRI));
    end

    // host power-state pins cross into this clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_s1 <= PWR_RUN;
            pwr_s2 <= PWR_RUN;
        end else begin
            pwr_s1 <= host_pwr;
            pwr_s2 <= pwr_s1;
        end
    end
    assign run_s = (pwr_s2 == PWR_RUN);

    assign ev_live  = ev & ~mask_q;
    assign pass_set = ev_live & ~local_q;

    irq_pick #(.NSRC(NSRC), .PRI_W(PRI_W)) pick_i (
        .req_i(req_q & ~mask_q), .prio_i(prio_q),
        .any_o(any_req), .win_o(win_id)
    );

    irq_dispatch_fsm #(.IDW(IDW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .any_i(any_req), .win_i(win_id),
        .done_i(hnd_done), .start_o(hnd_start), .id_o(hnd_id),
        .grant_o(grant), .report_o(report), .wait_o(in_wait)
    );

    always_comb begin
        grant_vec = '0;
        rep_set   = '0;
        if (grant)  grant_vec[win_id] = 1'b1;
        if (report) rep_set[hnd_id]   = 1'b1;
        rep_set = rep_set & ~mask_q;
    end

    assign pend_set = pass_set | rep_set;

    always_comb begin
        last_nxt = last_id;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_set[i]) last_nxt = IDW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            pend_q   <= '0;
            wake_q   <= '0;
            last_id  <= '0;
            last_vld <= 1'b0;
        end else begin
            req_q  <= (req_q & ~grant_vec) | (ev_live & local_q);
            pend_q <= (pend_q & ~clr) | pend_set;
            wake_q <= (wake_q & ~clr & ~pend_set) | pass_set | (rep_set & urgent);
            if (|pend_set) begin
                last_id  <= last_nxt;
                last_vld <= 1'b1;
            end
        end
    end

    assign host_irq = |(pend_q & ~mask_q & (wake_q | {NSRC{run_s}}));

endmodule

// File: rtl/irq_offload_ctrl_chk.sv
`timescale 1ns/1ps
module irq_offload_ctrl_chk
    import irq_ofl_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int AW   = 4,
    parameter int DW   = 8,
    parameter int IDW  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hnd_start,
    input logic            hnd_done,
    input logic [IDW-1:0]  hnd_id,
    input logic            host_irq,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [NSRC-1:0] pend_q,
    input logic [NSRC-1:0] mask_q,
    input logic [NSRC-1:0] pend_set,
    input logic            in_wait
);

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |=> !hnd_start);

    p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> $stable(hnd_id));

    p_report_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && hnd_done && !mask_q[hnd_id]) |=> pend_q[$past(hnd_id)]);

    p_irq_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (|(pend_q & ~mask_q)));

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[g]) |-> !$past(mask_q[g]));

        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && int'(reg_addr) == RA_PEND && reg_wdata[g] && !pend_set[g])
                |=> !pend_q[g]);
    end

endmodule

bind irq_offload_ctrl irq_offload_ctrl_chk #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .IDW(IDW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .hnd_start(hnd_start), .hnd_done(hnd_done),
    .hnd_id(hnd_id), .host_irq(host_irq), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_q(pend_q),
    .mask_q(mask_q), .pend_set(pend_set), .in_wait(in_wait)
);

// File: tb/irq_offload_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_offload_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_i = '0;
    logic [1:0] host_pwr = 2'b00;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       hnd_start;
    logic [1:0] hnd_id;
    logic       hnd_done = 1'b0;
    logic       host_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    logic [1:0] start_log [8];
    int log_n = 0;
    int hcnt = 0;

    always #2.5 clk = ~clk;

    irq_offload_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .host_pwr(host_pwr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hnd_start(hnd_start), .hnd_id(hnd_id),
        .hnd_done(hnd_done), .host_irq(host_irq)
    );

    // handler model: completes three falling edges after each start
    always @(negedge clk) begin
        hnd_done = 1'b0;
        if (rst_n) begin
            if (hnd_start) begin
                if (log_n < 8) start_log[log_n] = hnd_id;
                log_n = log_n + 1;
                hcnt = 3;
            end else if (hcnt > 0) begin
                hcnt = hcnt - 1;
                if (hcnt == 0) hnd_done = 1'b1;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_we = 1'b1;
        reg_addr = 4'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        reg_addr = 4'(a);
        #0.5;
        d = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [7:0] rv;

    initial begin
        #1000000;
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R11 reset state
        rd(0, rv); chk("R11 mask reset", rv, 8'h0F);
        rd(1, rv); chk("R11 local reset", rv, 8'h00);
        rd(2, rv); chk("R11 wake reset", rv, 8'h00);
        rd(3, rv); chk("R11 pend reset", rv, 8'h00);
        rd(4, rv); chk("R11 last reset", rv, 8'h00);
        chk("R11 irq reset", host_irq, 1'b0);
        chk("R11 start reset", hnd_start, 1'b0);

        // R2 R3 R4 R8 R10: every source, every trigger mode, pass-through
        for (int i = 0; i < 4; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic inact;
                inact = (m == 1 || m == 3);
                host_pwr = 2'(i);
                wr(0, 8'h0F);
                src_i[i] = inact;
                tick(4);
                wr(1, 8'h00);
                wr(8 + i, 8'(m));
                wr(0, 8'h0F & ~(8'h01 << i));
                tick(3);
                wr(3, 8'h0F);
                chk("R1 quiet before event", host_irq, 1'b0);
                src_i[i] = ~inact;
                tick(2);
                chk("R3 not before third edge", host_irq, 1'b0);
                tick(1);
                chk("R2 R4 irq on third edge", host_irq, 1'b1);
                rd(3, rv); chk("R2 pend bit", rv, 8'h01 << i);
                rd(4, rv); chk("R10 last source", rv, 8'h80 | 8'(i));
                if (m >= 2) begin
                    src_i[i] = inact;
                    tick(4);
                    wr(3, 8'h0F);
                    rd(3, rv); chk("R8 edge cleared", rv, 8'h00);
                    chk("R8 irq drops", host_irq, 1'b0);
                end else begin
                    wr(3, 8'h0F);
                    rd(3, rv); chk("R8 level stays pending", rv, 8'h01 << i);
                    src_i[i] = inact;
                    tick(4);
                    wr(3, 8'h0F);
                    rd(3, rv); chk("R8 level cleared", rv, 8'h00);
                end
            end
        end
        host_pwr = 2'b00;
        wr(0, 8'h0F);
        src_i = '0;
        tick(4);

        // R1 masked local source is ignored
        wr(1, 8'h01);
        wr(8, 8'h02);
        wr(3, 8'h0F);
        log_n = 0;
        src_i[0] = 1'b1;
        tick(12);
        rd(3, rv); chk("R1 masked no pend", rv, 8'h00);
        chk("R1 masked no irq", host_irq, 1'b0);
        chk("R1 masked no start", log_n, 0);
        src_i[0] = 1'b0;
        tick(4);

        // R5 local handshake timing
        wr(0, 8'h0E);
        tick(2);
        wr(3, 8'h0F);
        log_n = 0;
        src_i[0] = 1'b1;
        tick(3);
        chk("R5 no start yet", hnd_start, 1'b0);
        tick(1);
        chk("R5 start pulse", hnd_start, 1'b1);
        chk("R5 start id", hnd_id, 2'd0);
        chk("R5 irq held during handling", host_irq, 1'b0);
        tick(1);
        chk("R5 start single cycle", hnd_start, 1'b0);
        tick(2);
        chk("R5 irq low while done pending", host_irq, 1'b0);
        tick(1);
        chk("R5 irq after done", host_irq, 1'b1);
        rd(3, rv); chk("R5 pend after done", rv, 8'h01);
        src_i[0] = 1'b0;
        tick(4);
        wr(3, 8'h0F);
        chk("R8 irq cleared", host_irq, 1'b0);

        // R6 R7 wake decision sweep on source 0 (local, rising)
        for (int p = 1; p < 4; p++) begin
            for (int we = 0; we < 2; we++) begin
                for (int pr = 0; pr < 4; pr++) begin
                    host_pwr = 2'(p);
                    wr(8, 8'((pr << 2) | 2));
                    wr(2, 8'(we));
                    tick(3);
                    wr(3, 8'h0F);
                    src_i[0] = 1'b1;
                    tick(1);
                    src_i[0] = 1'b0;
                    tick(14);
                    rd(3, rv); chk("R6 R3 pulse held pending", rv, 8'h01);
                    chk("R6 wake decision", host_irq, (we == 1 && pr >= 2));
                    host_pwr = 2'b00;
                    tick(2);
                    chk("R7 irq on return to run", host_irq, 1'b1);
                    wr(3, 8'h0F);
                    chk("R8 cleared after wake", host_irq, 1'b0);
                end
            end
        end
        wr(2, 8'h00);

        // R9 dispatch order sweep
        begin
            logic [1:0] pat_p [4][4];
            logic [1:0] pat_o [4][4];
            pat_p[0] = '{2'd1, 2'd3, 2'd3, 2'd0}; pat_o[0] = '{2'd1, 2'd2, 2'd0, 2'd3};
            pat_p[1] = '{2'd2, 2'd2, 2'd2, 2'd2}; pat_o[1] = '{2'd0, 2'd1, 2'd2, 2'd3};
            pat_p[2] = '{2'd0, 2'd1, 2'd2, 2'd3}; pat_o[2] = '{2'd3, 2'd2, 2'd1, 2'd0};
            pat_p[3] = '{2'd3, 2'd0, 2'd3, 2'd1}; pat_o[3] = '{2'd0, 2'd2, 2'd3, 2'd1};
            for (int k = 0; k < 4; k++) begin
                wr(0, 8'h0F);
                src_i = '0;
                tick(4);
                wr(1, 8'h0F);
                for (int s = 0; s < 4; s++) wr(8 + s, 8'({pat_p[k][s], 2'b10}));
                wr(0, 8'h00);
                tick(2);
                wr(3, 8'h0F);
                log_n = 0;
                src_i = 4'hF;
                tick(40);
                chk("R9 dispatch count", log_n, 4);
                for (int s = 0; s < 4; s++)
                    chk("R9 dispatch order", start_log[s], pat_o[k][s]);
                rd(3, rv); chk("R9 all pending", rv, 8'h0F);
                src_i = '0;
                tick(4);
                wr(3, 8'h0F);
            end
        end

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule